// File: doc/BRIEF.md
# Header word extractor

The block lifts up to nine 16-bit words out of the first bytes of a frame and places them in one slice of a classifier key. Each extraction slot has an 8-bit configuration that names a reference boundary, either the end of the layer-2 header or the end of the layer-3 header. It also gives a distance from that boundary counted in 2-byte steps. A typical set-up points four slots at word offsets 6 to 9 past the layer-2 end, which covers the IPv4 source and destination addresses. Two more slots point at word offsets 0 and 1 past the layer-3 end, which covers the transport source and destination ports.

Frames arrive one byte per accepted beat, marked with start and end flags. The boundary positions come from an upstream parser on the start beat. The block does not search for the boundaries itself. When the end flag arrives, or the last byte of the header window is accepted, the block publishes the key words, a per-slot valid vector and a done flag. It holds all of them until the next frame starts. Software writes the slot configurations through a byte-wide write port with one register per slot.

Top module: `hdr_word_extract`

## Requirements
- R1: Slot k's configuration byte has reference select in bits [7:6] and word offset in bits [5:0]. A select of 01 uses the layer-2 end. The target byte position is that reference plus twice the offset, where the start byte is position 0. The byte at the target goes to key_o[16k+15:16k+8] and the following byte goes to key_o[16k+7:16k].
- R2: A select of 10 uses the layer-3 end as the reference. Both boundary inputs are sampled on the start beat.
- R3: A slot with select 00 or 11 is unused, and this includes an all-zero configuration byte. An unused slot never asserts its valid bit and reports a zero word.
- R4: A write stores cfg_wdata_i into slot cfg_addr_i/4. A write is ignored when cfg_addr_i is not a multiple of 4 or when the slot index is NUM_SLOTS or above.
- R5: A slot is valid only if both of its bytes arrived before the frame ended. A byte that never arrived reads as zero in the word.
- R6: Only positions 0 to WIN_BYTES-1 are collected. Results are published one cycle after the beat carrying the end flag or position WIN_BYTES-1, whichever comes first. done_o is high from that point.
- R7: Key, valid and done outputs hold their values until a start beat. Out of reset they are zero. A start beat that does not also close the window clears all of them on the next cycle.
- R8: Configurations are captured on the start beat. A write during a frame, or on its start beat, affects only later frames.
- R9: valid_lo_o carries the valid bits of slots 0 to 7. valid_hi_o carries slots 8 and up.
- R10: Cycles with byte_valid_i low are skipped without advancing the position. Bytes outside a frame, meaning after the window closes and before the next start, are ignored. A start beat in the middle of a frame restarts collection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | ADDR_W | Byte address of slot register (4 per slot) |
| cfg_wdata_i | input | 8 | Slot configuration byte |
| byte_valid_i | input | 1 | Byte beat qualifier |
| byte_i | input | 8 | Frame byte |
| sof_i | input | 1 | First byte of frame |
| eof_i | input | 1 | Last byte of frame |
| l2_end_i | input | POS_W | Byte position just past the layer-2 header |
| l3_end_i | input | POS_W | Byte position just past the layer-3 header |
| key_o | output | 16*NUM_SLOTS | Extracted words, slot k at [16k+15:16k] |
| valid_lo_o | output | 8 | Valid bits of slots 0 to 7 |
| valid_hi_o | output | NUM_SLOTS-8 | Valid bits of slots 8 and up |
| done_o | output | 1 | Result published for the current frame |

## Verification
On every cycle, the assertions check the following. Published outputs stay frozen while done is high and no start beat arrives. A valid bit never stands without done. done only falls after a start beat. Ignored register writes leave the configuration untouched. An unused slot collects nothing. A slot never holds a low byte without its high byte. The collection position stays inside the window.

Only the bench scenarios can show correct placement. This covers which byte lands in which key word under each reference, and the cut-off at the window edge and at a short frame. It also covers the snapshot of configuration at the start beat, skipped idle beats, and a restart in mid-frame. The bench compares every output against a byte-queue model on every clock.

// File: rtl/hwx_pkg.sv
package hwx_pkg;
  localparam int unsigned CFG_W = 8;
  localparam int unsigned OFF_W = 6;
  localparam int unsigned WORD_W = 16;

  typedef enum logic [1:0] {
    REF_NONE = 2'b00,
    REF_L2   = 2'b01,
    REF_L3   = 2'b10,
    REF_RSVD = 2'b11
  } ref_sel_e;
endpackage

// File: rtl/hwx_cfg_regs.sv
module hwx_cfg_regs #(
  parameter int unsigned NUM_SLOTS = 9,
  parameter int unsigned ADDR_W    = 6
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                we_i,
  input  logic [ADDR_W-1:0]                   addr_i,
  input  logic [hwx_pkg::CFG_W-1:0]           wdata_i,
  output logic [NUM_SLOTS*hwx_pkg::CFG_W-1:0] cfg_o
);
  import hwx_pkg::*;
  localparam int unsigned SLOT_AW = ADDR_W - 2;

  logic aligned;
  assign aligned = (addr_i[1:0] == 2'b00);

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_reg
    logic [CFG_W-1:0] cfg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cfg_q <= '0;
      else if (we_i && aligned && addr_i[ADDR_W-1:2] == SLOT_AW'(k)) cfg_q <= wdata_i;
    end
    assign cfg_o[k*CFG_W +: CFG_W] = cfg_q;
  end

  logic bad_wr;
  assign bad_wr = we_i && (!aligned || (32'(addr_i[ADDR_W-1:2]) >= NUM_SLOTS));

  assert_bad_write_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_wr |=> $stable(cfg_o));
endmodule

// File: rtl/hwx_pos_track.sv
module hwx_pos_track #(
  parameter int unsigned WIN_BYTES = 64,
  parameter int unsigned PW        = $clog2(WIN_BYTES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          byte_valid_i,
  input  logic          sof_i,
  input  logic          eof_i,
  output logic          take_o,
  output logic          sof_beat_o,
  output logic          end_beat_o,
  output logic [PW-1:0] cur_pos_o
);
  logic          active_q;
  logic [PW-1:0] pos_q;

  assign sof_beat_o = byte_valid_i && sof_i;
  assign cur_pos_o  = sof_beat_o ? '0 : pos_q;
  assign take_o     = sof_beat_o || (byte_valid_i && active_q);
  assign end_beat_o = take_o && (eof_i || cur_pos_o == PW'(WIN_BYTES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      pos_q    <= '0;
    end else if (take_o) begin
      active_q <= !end_beat_o;
      pos_q    <= cur_pos_o + PW'(1);
    end
  end

  assert_pos_in_window_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (32'(pos_q) < WIN_BYTES));
  assert_closed_after_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_beat_o |=> !active_q);
endmodule

// File: rtl/hwx_slot.sv
module hwx_slot #(
  parameter int unsigned POS_W = 8,
  parameter int unsigned PW    = 7,
  parameter int unsigned CMP_W = 11
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        take_i,
  input  logic                        sof_beat_i,
  input  logic [PW-1:0]               cur_pos_i,
  input  logic [7:0]                  data_i,
  input  logic [hwx_pkg::CFG_W-1:0]   cfg_i,
  input  logic [POS_W-1:0]            l2_end_i,
  input  logic [POS_W-1:0]            l3_end_i,
  output logic [hwx_pkg::WORD_W-1:0]  word_o,
  output logic                        ok_o
);
  import hwx_pkg::*;

  ref_sel_e          sel_new;
  logic              en_new, en_q, en_c;
  logic [POS_W-1:0]  base_new;
  logic [CMP_W-1:0]  tgt_new, tgt_q, tgt_c, pos_c;
  logic [WORD_W-1:0] word_q, word_b, word_n;
  logic              hi_q, lo_q, hi_b, lo_b, hi_n, lo_n, hit_hi, hit_lo;

  assign sel_new  = ref_sel_e'(cfg_i[7:6]);
  assign en_new   = (sel_new == REF_L2) || (sel_new == REF_L3);
  assign base_new = (sel_new == REF_L3) ? l3_end_i : l2_end_i;
  assign tgt_new  = CMP_W'(base_new) + (CMP_W'(cfg_i[OFF_W-1:0]) << 1);

  // snapshot taken on the start beat, used for that beat as well
  assign en_c   = sof_beat_i ? en_new  : en_q;
  assign tgt_c  = sof_beat_i ? tgt_new : tgt_q;
  assign word_b = sof_beat_i ? '0 : word_q;
  assign hi_b   = sof_beat_i ? 1'b0 : hi_q;
  assign lo_b   = sof_beat_i ? 1'b0 : lo_q;
  assign pos_c  = CMP_W'(cur_pos_i);

  assign hit_hi = take_i && en_c && (pos_c == tgt_c);
  assign hit_lo = take_i && en_c && (pos_c == tgt_c + CMP_W'(1));

  assign word_n = {hit_hi ? data_i : word_b[15:8], hit_lo ? data_i : word_b[7:0]};
  assign hi_n   = hi_b || hit_hi;
  assign lo_n   = lo_b || hit_lo;

  assign word_o = word_n;
  assign ok_o   = en_c && hi_n && lo_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      tgt_q  <= '0;
      word_q <= '0;
      hi_q   <= 1'b0;
      lo_q   <= 1'b0;
    end else if (take_i) begin
      en_q   <= en_c;
      tgt_q  <= tgt_c;
      word_q <= word_n;
      hi_q   <= hi_n;
      lo_q   <= lo_n;
    end
  end

  assert_unused_collects_nothing_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sof_beat_i && !en_new) |=> (!hi_q && !lo_q && word_q == '0));
  assert_low_needs_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_q |-> hi_q);
endmodule

// File: rtl/hdr_word_extract.sv
module hdr_word_extract #(
  parameter int unsigned NUM_SLOTS = 9,
  parameter int unsigned WIN_BYTES = 64,
  parameter int unsigned POS_W     = 8,
  parameter int unsigned ADDR_W    = 6
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  cfg_we_i,
  input  logic [ADDR_W-1:0]                     cfg_addr_i,
  input  logic [7:0]                            cfg_wdata_i,
  input  logic                                  byte_valid_i,
  input  logic [7:0]                            byte_i,
  input  logic                                  sof_i,
  input  logic                                  eof_i,
  input  logic [POS_W-1:0]                      l2_end_i,
  input  logic [POS_W-1:0]                      l3_end_i,
  output logic [NUM_SLOTS*hwx_pkg::WORD_W-1:0]  key_o,
  output logic [7:0]                            valid_lo_o,
  output logic [NUM_SLOTS-9:0]                  valid_hi_o,
  output logic                                  done_o
);
  import hwx_pkg::*;
  localparam int unsigned PW    = $clog2(WIN_BYTES + 1);
  localparam int unsigned TGT_W = POS_W + 2;
  localparam int unsigned CMP_W = ((TGT_W > PW) ? TGT_W : PW) + 1;
  localparam int unsigned KEY_W = NUM_SLOTS * WORD_W;

  logic [NUM_SLOTS*CFG_W-1:0] cfg;
  logic                       take, sof_beat, end_beat;
  logic [PW-1:0]              cur_pos;
  logic [KEY_W-1:0]           key_n, key_q;
  logic [NUM_SLOTS-1:0]       ok_n, vld_q;
  logic                       done_q;

  hwx_cfg_regs #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i), .cfg_o(cfg)
  );

  hwx_pos_track #(.WIN_BYTES(WIN_BYTES), .PW(PW)) u_pos (
    .clk_i, .rst_ni,
    .byte_valid_i, .sof_i, .eof_i,
    .take_o(take), .sof_beat_o(sof_beat), .end_beat_o(end_beat), .cur_pos_o(cur_pos)
  );

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    hwx_slot #(.POS_W(POS_W), .PW(PW), .CMP_W(CMP_W)) u_slot (
      .clk_i, .rst_ni,
      .take_i(take), .sof_beat_i(sof_beat), .cur_pos_i(cur_pos), .data_i(byte_i),
      .cfg_i(cfg[k*CFG_W +: CFG_W]), .l2_end_i, .l3_end_i,
      .word_o(key_n[k*WORD_W +: WORD_W]), .ok_o(ok_n[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q  <= '0;
      vld_q  <= '0;
      done_q <= 1'b0;
    end else if (end_beat) begin
      key_q  <= key_n;
      vld_q  <= ok_n;
      done_q <= 1'b1;
    end else if (sof_beat) begin
      key_q  <= '0;
      vld_q  <= '0;
      done_q <= 1'b0;
    end
  end

  assign key_o      = key_q;
  assign valid_lo_o = vld_q[7:0];
  assign valid_hi_o = vld_q[NUM_SLOTS-1:8];
  assign done_o     = done_q;

  assert_hold_until_sof_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !(byte_valid_i && sof_i)) |=> ($stable(key_o) && $stable(valid_lo_o)
                                              && $stable(valid_hi_o) && done_o));
  assert_valid_needs_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|valid_lo_o) || (|valid_hi_o)) |-> done_o);
  assert_done_falls_on_sof_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_o) |-> $past(byte_valid_i && sof_i));
endmodule

// File: tb/hdr_word_extract_test.sv
`timescale 1ns/1ps
module hdr_word_extract_test;
  localparam int NS  = 9;
  localparam int WIN = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 0; logic [5:0] addr = 0; logic [7:0] wdata = 0;
  logic bv = 0; logic [7:0] din = 0; logic sof = 0, eof = 0;
  logic [7:0] l2 = 0, l3 = 0;
  logic [NS*16-1:0] key_o;
  logic [7:0] valid_lo_o;
  logic [0:0] valid_hi_o;
  logic done_o;

  always #2.5 clk = ~clk;

  hdr_word_extract #(.NUM_SLOTS(NS), .WIN_BYTES(WIN), .POS_W(8), .ADDR_W(6)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .byte_valid_i(bv), .byte_i(din), .sof_i(sof), .eof_i(eof),
    .l2_end_i(l2), .l3_end_i(l3),
    .key_o(key_o), .valid_lo_o(valid_lo_o), .valid_hi_o(valid_hi_o), .done_o(done_o)
  );

  int checks = 0, errors = 0;
  string tag = "R7";

  // behavioural reference
  int m_cfg[NS], s_cfg[NS];
  int s_l2, s_l3;
  logic [7:0] fb[$];
  bit m_act = 0;
  logic [NS*16-1:0] e_key = '0;
  logic [NS-1:0] e_vld = '0;
  bit e_done = 0;

  task automatic publish();
    for (int k = 0; k < NS; k++) begin
      int c, sel, p;
      logic [7:0] hi, lo;
      c = s_cfg[k]; sel = c >> 6;
      if (sel == 1 || sel == 2) begin
        p  = ((sel == 1) ? s_l2 : s_l3) + 2 * (c & 63);
        hi = (p < fb.size()) ? fb[p] : 8'h00;
        lo = (p + 1 < fb.size()) ? fb[p+1] : 8'h00;
        e_key[16*k +: 16] = {hi, lo};
        e_vld[k] = (p + 1 < fb.size());
      end else begin
        e_key[16*k +: 16] = '0;
        e_vld[k] = 1'b0;
      end
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NS; k++) m_cfg[k] = 0;
      m_act = 0; e_key = '0; e_vld = '0; e_done = 0;
    end else begin
      if (bv) begin
        if (sof) begin
          fb.delete();
          for (int k = 0; k < NS; k++) s_cfg[k] = m_cfg[k];
          s_l2 = l2; s_l3 = l3; m_act = 1;
        end
        if (m_act) begin
          fb.push_back(din);
          if (eof || fb.size() == WIN) begin
            publish(); m_act = 0; e_done = 1;
          end else if (sof) begin
            e_done = 0; e_vld = '0; e_key = '0;
          end
        end
      end
      if (we && addr % 4 == 0 && addr / 4 < NS) m_cfg[addr/4] = wdata;
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (key_o !== e_key || {valid_hi_o, valid_lo_o} !== e_vld || done_o !== e_done) begin
        errors++;
        $display("FAIL %s key=%h exp=%h vld=%h exp=%h done=%b exp=%b",
                 tag, key_o, e_key, {valid_hi_o, valid_lo_o}, e_vld, done_o, e_done);
      end
    end
  end

  task automatic chk(bit ok, string t, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic cfg_wr(int a, int d);
    @(negedge clk); we = 1; addr = 6'(a); wdata = 8'(d);
    @(negedge clk); we = 0;
  endtask

  task automatic frame(int len, int l2v, int l3v, int seed, int gap, int term,
                       int wr_at, int wr_a, int wr_d);
    for (int i = 0; i < len; i++) begin
      if (gap != 0 && (i % 3) == 1) begin
        @(negedge clk); bv = 0; sof = 0; eof = 0; we = 0;
      end
      @(negedge clk);
      bv = 1; din = 8'(seed * 7 + i * 13 + 1);
      sof = (i == 0); eof = (term != 0) && (i == len - 1);
      l2 = 8'(l2v); l3 = 8'(l3v);
      we = (i == wr_at); addr = 6'(wr_a); wdata = 8'(wr_d);
    end
    @(negedge clk); bv = 0; sof = 0; eof = 0; we = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic stray(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bv = 1; sof = 0; eof = (i == n - 1); din = 8'(i * 5 + 3);
    end
    @(negedge clk); bv = 0; eof = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(done_o == 0 && key_o == '0 && valid_lo_o == 0 && valid_hi_o == 0,
        "R7 reset outputs", {31'd0, done_o}, 32'd0);

    // R1 / R2: address and port words
    tag = "R1";
    for (int k = 0; k < 4; k++) cfg_wr(4 * k, 8'h40 | (6 + k));
    cfg_wr(16, 8'h80); cfg_wr(20, 8'h81);
    cfg_wr(32, 8'h40);
    frame(60, 14, 34, 1, 0, 1, -1, 0, 0);
    chk(valid_lo_o == 8'h3F, "R1 slots 0-5 valid", valid_lo_o, 8'h3F);
    tag = "R9";
    chk(valid_hi_o == 1'b1, "R9 slot 8 in upper valid", valid_hi_o, 1);
    tag = "R2";
    frame(50, 2, 22, 2, 0, 1, -1, 0, 0);

    // R3: zero and reserved selectors
    tag = "R3";
    cfg_wr(0, 8'h00); cfg_wr(4, 8'h05); cfg_wr(8, 8'hC3);
    frame(40, 4, 10, 3, 0, 1, -1, 0, 0);
    chk(valid_lo_o[2:0] == 3'b000, "R3 unused slots invalid", valid_lo_o, 8'h38);

    // R4: misaligned and out-of-range writes are dropped
    tag = "R4";
    cfg_wr(5, 8'h41); cfg_wr(36, 8'h42); cfg_wr(40, 8'h43);
    frame(40, 4, 10, 4, 0, 1, -1, 0, 0);
    chk(valid_lo_o[1:0] == 2'b00, "R4 ignored writes", valid_lo_o, 8'h38);

    // R5: frame ends inside a word
    tag = "R5";
    cfg_wr(0, 8'h40); cfg_wr(4, 8'h80); cfg_wr(8, 8'h81);
    frame(20, 18, 19, 5, 0, 1, -1, 0, 0);
    chk(valid_lo_o[1:0] == 2'b01, "R5 half word invalid", valid_lo_o, 0);

    // R6: window cut-off on a long frame
    tag = "R6";
    cfg_wr(0, 8'h40); cfg_wr(4, 8'h80); cfg_wr(8, 8'h81);
    frame(80, 62, 63, 6, 0, 1, -1, 0, 0);
    chk(valid_lo_o[2:0] == 3'b001, "R6 last window word only", valid_lo_o, 1);

    // R7 / R10: outputs hold through idle and stray bytes
    tag = "R7";
    repeat (5) @(negedge clk);
    tag = "R10";
    stray(6);
    repeat (3) @(negedge clk);

    // R8: write during a frame takes effect next frame
    tag = "R8";
    frame(40, 4, 10, 7, 0, 1, 5, 0, 8'h41);
    frame(40, 4, 10, 8, 0, 1, 0, 4, 8'h42);
    frame(40, 4, 10, 9, 0, 1, -1, 0, 0);

    // R10: gaps inside a frame and restart mid-frame
    tag = "R10";
    frame(45, 12, 30, 10, 1, 1, -1, 0, 0);
    frame(10, 0, 4, 11, 0, 0, -1, 0, 0);
    frame(30, 0, 4, 12, 0, 1, -1, 0, 0);
    tag = "R1";
    cfg_wr(0, 8'h40);
    frame(1, 0, 0, 13, 0, 1, -1, 0, 0);
    chk(valid_lo_o[0] == 1'b0 && done_o, "R1 single-byte frame", valid_lo_o, 0);

    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule